// File: doc/BRIEF.md
# Even/Odd Derandomizer Buffer Selector with CRC Gating

This block sits in the fast front-end clock domain beside a set of serial links. Each link feeds a pair of derandomizer FIFOs, an even half and an odd half, and reports the outcome of its frame CRC check as one-cycle strobes: a CRC-valid strobe and, on the same cycle, a CRC-bad qualifier. From those strobes the block works out three things for each link. It decides which half is being filled. It decides when a half must be flushed because the frame stored in it failed its check. It decides when the read side may begin moving a finished frame out.

Buffering is held back until every link has delivered at least one good frame. Each link keeps a sticky arming flag, and the global write enable is the AND of all flags. While that enable is low the half selection stays fixed. Once it is high, every checked frame flips the selection of its link, whether the CRC matched or not. A failed frame also clears the half that was being filled, so the next frame goes to the other half and the ping-pong rhythm never stalls. A good frame produces a read-start strobe two cycles later, so the active-half flag has settled, and only while that link's read side reports data present.

Top module: `pp_fifo_sel`

## Requirements
- R1: Per link, a strobe with crc_valid_i=1 and crc_bad_i=0 is a good frame and one with crc_valid_i=1 and crc_bad_i=1 is a failed frame. crc_bad_i with crc_valid_i=0 has no effect on any output.
- R2: A good frame sets that link's arm_o bit on the next clock edge. The bit then stays set through failed frames and clear-all, and only reset clears it.
- R3: wr_enable_o is 1 exactly when every bit of arm_o is 1.
- R4: While wr_enable_o is 0 at the clock edge, no sel_odd_o bit changes on that edge. This includes the strobe that completes arming.
- R5: When wr_enable_o is 1, each CRC-valid strobe, good or failed, inverts that link's sel_odd_o on the next edge (0 = even half, 1 = odd half).
- R6: A failed frame gives a one-cycle pulse, starting the next cycle, on clr_even_o of that link if sel_odd_o was 0 at the strobe, or on clr_odd_o if it was 1. The other half gets no pulse.
- R7: clear_all_i sampled high drives every clr_even_o and clr_odd_o bit high for the following cycle.
- R8: rd_start_o of a link is 1 exactly when that link had a good frame two edges earlier and rd_empty_i of that link is currently 0. Failed frames never produce it.
- R9: After reset, arm_o, wr_enable_o, sel_odd_o, all clear outputs and rd_start_o are 0.
- R10: The links are independent: strobes on one link change only that link's arm, selection, clear and start outputs, apart from the shared wr_enable_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Front-end clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| crc_valid_i | input | N_LINKS | One-cycle CRC-check-done strobe per link |
| crc_bad_i | input | N_LINKS | CRC mismatch qualifier, meaningful with crc_valid_i |
| clear_all_i | input | 1 | Clear every FIFO half |
| rd_empty_i | input | N_LINKS | Read side of the link's active FIFO is empty |
| arm_o | output | N_LINKS | Sticky per-link arming flags |
| wr_enable_o | output | 1 | Global buffering enable |
| sel_odd_o | output | N_LINKS | Half being filled, 0 even, 1 odd |
| clr_even_o | output | N_LINKS | Clear pulse for the even FIFO of each link |
| clr_odd_o | output | N_LINKS | Clear pulse for the odd FIFO of each link |
| rd_start_o | output | N_LINKS | Read-side transfer start strobe |

## Verification
Arming, selection and clear results are due one edge after the strobe that causes them. wr_enable_o follows the arming flags in the same cycle. The read-start strobe is due two edges after a good frame and reacts to rd_empty_i at once, with no edge in between. The bench drives every input one time unit after a rising edge. It checks the start strobe once the new rd_empty_i has settled and before the next edge. It checks the registered results one time unit after that edge, against a model advanced by exactly those edge counts.

// File: rtl/pp_sel_pkg.sv
package pp_sel_pkg;

  typedef enum logic {
    HALF_EVEN = 1'b0,
    HALF_ODD  = 1'b1
  } half_e;

  typedef struct packed {
    logic seen;  // CRC check finished
    logic good;  // finished and matched
    logic fail;  // finished and mismatched
  } crc_ev_t;

  function automatic crc_ev_t decode_crc(input logic valid, input logic bad);
    crc_ev_t ev;
    ev.seen = valid;
    ev.good = valid & ~bad;
    ev.fail = valid & bad;
    return ev;
  endfunction

endpackage

// File: rtl/pp_arm_latch.sv
module pp_arm_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic good_i,
  output logic armed_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_o <= 1'b0;
    else if (good_i) armed_o <= 1'b1;
  end

endmodule

// File: rtl/pp_half_ctrl.sv
module pp_half_ctrl
  import pp_sel_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    armed_all_i,
  input  crc_ev_t ev_i,
  input  logic    clear_all_i,
  output logic    sel_odd_o,
  output logic    clr_even_o,
  output logic    clr_odd_o
);

  half_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= HALF_EVEN;
      clr_even_o <= 1'b0;
      clr_odd_o  <= 1'b0;
    end else begin
      // flush the half that held the failed frame
      clr_even_o <= clear_all_i | (ev_i.fail & (sel_q == HALF_EVEN));
      clr_odd_o  <= clear_all_i | (ev_i.fail & (sel_q == HALF_ODD));
      if (armed_all_i && ev_i.seen)
        sel_q <= (sel_q == HALF_EVEN) ? HALF_ODD : HALF_EVEN;
    end
  end

  assign sel_odd_o = (sel_q == HALF_ODD);

endmodule

// File: rtl/pp_start_delay.sv
module pp_start_delay #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic good_i,
  input  logic rd_empty_i,
  output logic start_o
);

  logic [DEPTH-1:0] pipe_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= good_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[DEPTH-2:0], good_i};
      end
    end
  endgenerate

  assign start_o = pipe_q[DEPTH-1] & ~rd_empty_i;

endmodule

// File: rtl/pp_fifo_sel.sv
module pp_fifo_sel
  import pp_sel_pkg::*;
#(
  parameter int unsigned N_LINKS   = 2,
  parameter int unsigned START_LAT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINKS-1:0] crc_valid_i,
  input  logic [N_LINKS-1:0] crc_bad_i,
  input  logic               clear_all_i,
  input  logic [N_LINKS-1:0] rd_empty_i,
  output logic [N_LINKS-1:0] arm_o,
  output logic               wr_enable_o,
  output logic [N_LINKS-1:0] sel_odd_o,
  output logic [N_LINKS-1:0] clr_even_o,
  output logic [N_LINKS-1:0] clr_odd_o,
  output logic [N_LINKS-1:0] rd_start_o
);

  localparam int unsigned LAT_W = (START_LAT < 1) ? 1 : START_LAT;

  crc_ev_t ev [N_LINKS];

  assign wr_enable_o = &arm_o;

  for (genvar l = 0; l < N_LINKS; l++) begin : g_link
    assign ev[l] = decode_crc(crc_valid_i[l], crc_bad_i[l]);

    pp_arm_latch u_arm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .good_i  (ev[l].good),
      .armed_o (arm_o[l])
    );

    pp_half_ctrl u_half (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .armed_all_i (wr_enable_o),
      .ev_i        (ev[l]),
      .clear_all_i (clear_all_i),
      .sel_odd_o   (sel_odd_o[l]),
      .clr_even_o  (clr_even_o[l]),
      .clr_odd_o   (clr_odd_o[l])
    );

    pp_start_delay #(.DEPTH(LAT_W)) u_start (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .good_i     (ev[l].good),
      .rd_empty_i (rd_empty_i[l]),
      .start_o    (rd_start_o[l])
    );
  end

endmodule

// File: rtl/pp_fifo_sel_chk.sv
module pp_fifo_sel_chk #(
  parameter int unsigned N_LINKS   = 2,
  parameter int unsigned START_LAT = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_LINKS-1:0] crc_valid_i,
  input logic [N_LINKS-1:0] crc_bad_i,
  input logic               clear_all_i,
  input logic [N_LINKS-1:0] rd_empty_i,
  input logic [N_LINKS-1:0] arm_o,
  input logic               wr_enable_o,
  input logic [N_LINKS-1:0] sel_odd_o,
  input logic [N_LINKS-1:0] clr_even_o,
  input logic [N_LINKS-1:0] clr_odd_o,
  input logic [N_LINKS-1:0] rd_start_o
);

  a_r4_frozen_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_enable_o |=> $stable(sel_odd_o));

  a_r7_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_all_i |=> (&clr_even_o) && (&clr_odd_o));

  for (genvar g = 0; g < N_LINKS; g++) begin : g_chk
    a_r2_arm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_o[g] |=> arm_o[g]);

    a_r1_good_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (crc_valid_i[g] && !crc_bad_i[g]) |=> arm_o[g]);

    a_r5_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_enable_o && crc_valid_i[g]) |=> (sel_odd_o[g] != $past(sel_odd_o[g])));

    a_r6_clear_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (crc_valid_i[g] && crc_bad_i[g] && !sel_odd_o[g]) |=> clr_even_o[g]);

    a_r6_clear_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (crc_valid_i[g] && crc_bad_i[g] && sel_odd_o[g]) |=> clr_odd_o[g]);

    a_r6_one_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clear_all_i |=> !(clr_even_o[g] && clr_odd_o[g]));

    a_r8_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_start_o[g] |-> !rd_empty_i[g]);

    if (START_LAT == 2) begin : g_lat2
      a_r8_after_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_start_o[g] |-> $past(crc_valid_i[g] && !crc_bad_i[g], 2));
    end
  end

endmodule

bind pp_fifo_sel pp_fifo_sel_chk #(.N_LINKS(N_LINKS), .START_LAT(START_LAT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .crc_valid_i (crc_valid_i),
  .crc_bad_i   (crc_bad_i),
  .clear_all_i (clear_all_i),
  .rd_empty_i  (rd_empty_i),
  .arm_o       (arm_o),
  .wr_enable_o (wr_enable_o),
  .sel_odd_o   (sel_odd_o),
  .clr_even_o  (clr_even_o),
  .clr_odd_o   (clr_odd_o),
  .rd_start_o  (rd_start_o)
);

// File: tb/sim_pp_fifo_sel.sv
`timescale 1ns/1ps
module sim_pp_fifo_sel;

  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] valid = '0, bad = '0, empty = '0;
  logic         clr_all = 1'b0;
  logic [N-1:0] arm, sel, clr_e, clr_o, start;
  logic         wen;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [N-1:0] m_arm = '0, m_sel = '0, m_ce = '0, m_co = '0, m_d1 = '0, m_d2 = '0;

  always #5 clk = ~clk;

  pp_fifo_sel #(.N_LINKS(N), .START_LAT(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .crc_valid_i(valid), .crc_bad_i(bad),
    .clear_all_i(clr_all), .rd_empty_i(empty), .arm_o(arm), .wr_enable_o(wen),
    .sel_odd_o(sel), .clr_even_o(clr_e), .clr_odd_o(clr_o), .rd_start_o(start)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_regs(input logic was_armed);
    chk("R1 R2 arm", arm, m_arm);
    chk("R3 wr_enable", {{(N-1){1'b0}}, wen}, {{(N-1){1'b0}}, &m_arm});
    chk(was_armed ? "R5 R10 selection" : "R4 selection", sel, m_sel);
    chk("R6 R7 clear even", clr_e, m_ce);
    chk("R6 R7 clear odd", clr_o, m_co);
  endtask

  task automatic cycle(input logic [N-1:0] v, input logic [N-1:0] b,
                       input logic ca, input logic [N-1:0] e);
    logic armed_now;
    valid = v; bad = b; clr_all = ca; empty = e;
    #1;
    chk("R8 start", start, m_d2 & ~e);
    armed_now = &m_arm;
    m_ce  = {N{ca}} | (v & b & ~m_sel);
    m_co  = {N{ca}} | (v & b & m_sel);
    if (armed_now) m_sel = m_sel ^ v;
    m_arm = m_arm | (v & ~b);
    m_d2  = m_d1;
    m_d1  = v & ~b;
    @(posedge clk); #1;
    check_regs(armed_now);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; valid = '0; bad = '0; clr_all = 1'b0; empty = '0;
    m_arm = '0; m_sel = '0; m_ce = '0; m_co = '0; m_d1 = '0; m_d2 = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R9 reset start", start, '0);
    check_regs(1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    @(posedge clk); #1;
    do_reset();
    // pre-arm: failed frames and bad without valid leave everything idle (R1, R4)
    cycle(2'b00, 2'b11, 1'b0, 2'b00);
    cycle(2'b11, 2'b11, 1'b0, 2'b00);
    cycle(2'b00, 2'b00, 1'b0, 2'b00);
    // only link 0 good: no global enable yet (R3, R10)
    cycle(2'b01, 2'b00, 1'b0, 2'b00);
    cycle(2'b00, 2'b00, 1'b0, 2'b00);
    cycle(2'b00, 2'b00, 1'b0, 2'b01);  // start of link 0 masked by empty (R8)
    // link 1 good completes arming; that strobe must not toggle (R4)
    cycle(2'b10, 2'b00, 1'b0, 2'b00);
    cycle(2'b00, 2'b00, 1'b0, 2'b00);
    cycle(2'b00, 2'b00, 1'b0, 2'b00);
    // near-exhaustive sweep of strobe combinations, clear-all and empty
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 16; k++) begin
        logic [3:0] kk;
        kk = 4'(k);
        cycle({kk[2], kk[0]}, {kk[3], kk[1]}, ((k + r) % 7) == 6,
              {((k + r) % 3) == 0, ((k + 2 * r) % 4) == 1});
      end
      cycle(2'b00, 2'b00, 1'b0, 2'b00);
      cycle(2'b00, 2'b00, 1'b0, 2'b00);
    end
    // reset in the middle clears the sticky flags (R2, R9)
    do_reset();
    cycle(2'b10, 2'b10, 1'b0, 2'b00);
    cycle(2'b00, 2'b00, 1'b0, 2'b00);
    cycle(2'b00, 2'b00, 1'b0, 2'b00);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule